// File: doc/BRIEF.md
# Multi-channel interrupt fan-out multiplexer

The block collects a vector of level-sensitive interrupt lines and presents all of them to a set of independent output channels. Each channel has two registers. One is a writable enable mask. The other is a read-only pending word. A channel raises its single interrupt line whenever at least one source is both active and enabled in that channel's mask. Software routes a source by setting its bit in the mask of the channel that should service it. When the interrupt arrives, software reads that channel's pending word and services every bit that is set.

The source lines may be asynchronous to the block clock, so they pass through a resynchroniser before any use. Registers are reached over a plain 32-bit register bus. A request is a single-cycle strobe with a write flag. The block accepts a request on every cycle and never stalls, so the bus has no back-pressure. Read data returns one cycle after the request, marked by a valid pulse. Writes produce no response.

The number of implemented channels is a parameter from 1 to 8. The register window always has room for eight channel slots. Slots beyond the implemented count behave as empty space.

Top module: `irq_fanout_mux`

## Requirements
- R1: After reset, every enable register reads zero, every pending word reads zero and every channel output is low.
- R2: The enable register of channel n is at byte offset 0x10 + 0x40*n. It stores and reads back all 32 written bits, and bit k enables source k.
- R3: The pending word of channel n is at byte offset 0x20 + 0x40*n. Bit k reads as one exactly when resynchronised source k is high and enable bit k of channel n is set.
- R4: Channel output n is high exactly while its pending word is non-zero, and it stays high for as long as an enabled source stays active.
- R5: A change on a source line that is present at one rising clock edge is first visible in the pending words and channel outputs after the second rising edge that follows. This is a two-register resynchroniser.
- R6: Writes to a pending word change neither that word nor any enable register nor any output.
- R7: A read of an offset that is not an enable or pending register of some slot returns zero, and a write to such an offset changes no enable register. Unmapped offsets include offsets that are not word aligned and offsets at or above 0x200.
- R8: When channel slot n is at or above the implemented channel count, its registers read zero and writes to them are ignored.
- R9: A read request returns its data on the following cycle, with the read-valid pulse high for exactly that cycle. Write requests and idle cycles never raise the read-valid pulse.
- R10: A write to one channel's enable register leaves every other channel's enable register unchanged, so a read-modify-write of one bit changes only that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous reset, active low |
| src_irq_i | input | SRC_W | Level interrupt sources, may be asynchronous |
| bus_en_i | input | 1 | Register request strobe, accepted every cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid with bus_rvalid_o |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after a read |
| irq_o | output | NUM_CH | One level interrupt per channel |

## Verification
The hardest condition to produce from the ports is a combined state: different masks in every channel, a source pattern that drives some outputs and leaves others quiet, and a second instance with fewer channels that sees the same bus traffic. The bench gives each channel a distinct mask and then walks a single active source across all 32 positions. For each position it compares every output and every pending word with the bitwise AND it computes itself. Two instances, one with 8 channels and one with 3, share the bus. Every write to an unimplemented slot is therefore observed as a no-op on the smaller instance, while the larger instance shows the write.

// File: rtl/irqmux_pkg.sv
package irqmux_pkg;
  localparam int unsigned BUS_W      = 32;
  localparam int unsigned SLOT_MAX   = 8;
  localparam int unsigned SLOT_SPAN  = 'h40;
  localparam int unsigned OFS_ENABLE = 'h10;
  localparam int unsigned OFS_STATUS = 'h20;
  localparam int unsigned SLOT_BITS  = $clog2(SLOT_SPAN);
  localparam int unsigned IDX_BITS   = $clog2(SLOT_MAX);
  localparam int unsigned WIN_BITS   = SLOT_BITS + IDX_BITS;

  typedef enum logic [1:0] {
    KIND_NONE   = 2'd0,
    KIND_ENABLE = 2'd1,
    KIND_STATUS = 2'd2
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e             kind;
    logic [IDX_BITS-1:0]   slot;
  } reg_sel_t;
endpackage

// File: rtl/irqmux_src_sync.sv
module irqmux_src_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) chain_q[s] <= '0;
          else         chain_q[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) chain_q[s] <= '0;
          else         chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];

  // count edges since reset so the latency check never looks before reset
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)            warm_q <= '0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  generate
    if (STAGES == 2) begin : g_chk
      AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!arst_n)
        (warm_q == 2'd2) |-> (sync_o == $past(async_i, 2))); // R5
    end
  endgenerate
endmodule

// File: rtl/irqmux_chan_slot.sv
module irqmux_chan_slot #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] src_sync,
  output logic [W-1:0] en_o,
  output logic [W-1:0] pend_o,
  output logic         irq_o
);
  logic [W-1:0] en_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)    en_q <= '0;
    else if (wr_en) en_q <= wr_data;
  end

  assign en_o   = en_q;
  assign pend_o = src_sync & en_q;
  assign irq_o  = |pend_o;

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!arst_n)
    !wr_en |=> $stable(en_q)); // R10
endmodule

// File: rtl/irqmux_reg_if.sv
module irqmux_reg_if
  import irqmux_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned SRC_W  = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic                          clk,
  input  logic                          arst_n,
  input  logic                          bus_en,
  input  logic                          bus_wr,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [NUM_CH-1:0][SRC_W-1:0]  en_all,
  input  logic [NUM_CH-1:0][SRC_W-1:0]  pend_all,
  output logic [NUM_CH-1:0]             wr_strobe,
  output logic [BUS_W-1:0]              rdata,
  output logic                          rvalid
);
  logic [SLOT_BITS-1:0] ofs;
  logic [IDX_BITS-1:0]  idx;
  logic                 in_window;
  logic                 slot_live;
  reg_sel_t             sel;

  assign ofs = bus_addr[SLOT_BITS-1:0];
  assign idx = bus_addr[WIN_BITS-1:SLOT_BITS];

  generate
    if (ADDR_W > WIN_BITS) begin : g_hi
      assign in_window = (bus_addr[ADDR_W-1:WIN_BITS] == '0);
    end else begin : g_nohi
      assign in_window = 1'b1;
    end
  endgenerate

  assign slot_live = in_window && (int'(idx) < NUM_CH);

  always_comb begin
    sel.slot = idx;
    sel.kind = KIND_NONE;
    if (slot_live) begin
      if (int'(ofs) == OFS_ENABLE)      sel.kind = KIND_ENABLE;
      else if (int'(ofs) == OFS_STATUS) sel.kind = KIND_STATUS;
    end
  end

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      wr_strobe[c] = bus_en && bus_wr && (sel.kind == KIND_ENABLE)
                     && (sel.slot == IDX_BITS'(c));
    end
  end

  logic [BUS_W-1:0] rd_d;
  always_comb begin
    rd_d = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (sel.slot == IDX_BITS'(c)) begin
        if (sel.kind == KIND_ENABLE)      rd_d[SRC_W-1:0] = en_all[c];
        else if (sel.kind == KIND_STATUS) rd_d[SRC_W-1:0] = pend_all[c];
      end
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= bus_en && !bus_wr;
      rdata  <= (bus_en && !bus_wr) ? rd_d : '0;
    end
  end

  AST_RVALID_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!arst_n)
    (bus_en && !bus_wr) |=> rvalid); // R9
  AST_RVALID_ONLY_READ: assert property (@(posedge clk) disable iff (!arst_n)
    rvalid |-> $past(bus_en && !bus_wr)); // R9
  AST_EMPTY_SLOT_ZERO: assert property (@(posedge clk) disable iff (!arst_n)
    $past(bus_en && !bus_wr && !slot_live) |-> (rdata == '0)); // R8
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!arst_n)
    $onehot0(wr_strobe)); // R10
endmodule

// File: rtl/irq_fanout_mux.sv
module irq_fanout_mux
  import irqmux_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned SRC_W  = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic [SRC_W-1:0]  src_irq_i,
  input  logic              bus_en_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  output logic              bus_rvalid_o,
  output logic [NUM_CH-1:0] irq_o
);
  logic [SRC_W-1:0]             src_sync;
  logic [NUM_CH-1:0][SRC_W-1:0] en_all;
  logic [NUM_CH-1:0][SRC_W-1:0] pend_all;
  logic [NUM_CH-1:0]            wr_strobe;

  irqmux_src_sync #(.W(SRC_W), .STAGES(2)) u_sync (
    .clk     (clk),
    .arst_n  (arst_n),
    .async_i (src_irq_i),
    .sync_o  (src_sync)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      irqmux_chan_slot #(.W(SRC_W)) u_slot (
        .clk      (clk),
        .arst_n   (arst_n),
        .wr_en    (wr_strobe[c]),
        .wr_data  (bus_wdata_i[SRC_W-1:0]),
        .src_sync (src_sync),
        .en_o     (en_all[c]),
        .pend_o   (pend_all[c]),
        .irq_o    (irq_o[c])
      );

      AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!arst_n)
        irq_o[c] |-> (en_all[c] != '0)); // R4
      AST_IRQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!arst_n)
        irq_o[c] |-> (src_sync != '0)); // R3
    end
  endgenerate

  irqmux_reg_if #(.NUM_CH(NUM_CH), .SRC_W(SRC_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .arst_n    (arst_n),
    .bus_en    (bus_en_i),
    .bus_wr    (bus_wr_i),
    .bus_addr  (bus_addr_i),
    .en_all    (en_all),
    .pend_all  (pend_all),
    .wr_strobe (wr_strobe),
    .rdata     (bus_rdata_o),
    .rvalid    (bus_rvalid_o)
  );
endmodule

// File: tb/irq_fanout_mux_tb_top.sv
module irq_fanout_mux_tb_top;
  localparam int NB = 3;

  logic        clk = 1'b0;
  logic        arst_n = 1'b0;
  logic [31:0] src = '0;
  logic        ben = 1'b0, bwr = 1'b0;
  logic [11:0] badr = '0;
  logic [31:0] bwd = '0;
  logic [31:0] rd_a, rd_b;
  logic        rv_a, rv_b;
  logic [7:0]  irq_a;
  logic [NB-1:0] irq_b;

  always #4 clk = ~clk;

  irq_fanout_mux #(.NUM_CH(8)) dut_i (
    .clk(clk), .arst_n(arst_n), .src_irq_i(src), .bus_en_i(ben), .bus_wr_i(bwr),
    .bus_addr_i(badr), .bus_wdata_i(bwd), .bus_rdata_o(rd_a), .bus_rvalid_o(rv_a),
    .irq_o(irq_a));

  irq_fanout_mux #(.NUM_CH(NB)) dut_b (
    .clk(clk), .arst_n(arst_n), .src_irq_i(src), .bus_en_i(ben), .bus_wr_i(bwr),
    .bus_addr_i(badr), .bus_wdata_i(bwd), .bus_rdata_o(rd_b), .bus_rvalid_o(rv_b),
    .irq_o(irq_b));

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] mA [8];
  logic [31:0] mB [8];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] a_en(input int c);  return 12'('h10 + 'h40 * c); endfunction
  function automatic logic [11:0] a_st(input int c);  return 12'('h20 + 'h40 * c); endfunction
  function automatic logic [31:0] pat(input int c);   return (32'h9E3779B9 * 32'(c + 1)) ^ 32'h0000_FFFF; endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    ben = 1; bwr = 1; badr = a; bwd = d;
    for (int c = 0; c < 8; c++) begin
      if (a == a_en(c)) begin
        mA[c] = d;
        if (c < NB) mB[c] = d;
      end
    end
    @(negedge clk);
    ben = 0; bwr = 0;
    check(!rv_a && !rv_b, "R9 no rvalid after write", {30'b0, rv_b, rv_a}, 0);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] da, output logic [31:0] db);
    @(negedge clk);
    ben = 1; bwr = 0; badr = a;
    @(negedge clk);
    ben = 0;
    check(rv_a && rv_b, "R9 rvalid after read", {30'b0, rv_b, rv_a}, 3);
    da = rd_a; db = rd_b;
  endtask

  task automatic check_all_en(input string tag);
    logic [31:0] da, db;
    for (int c = 0; c < 8; c++) begin
      rd(a_en(c), da, db);
      check(da == mA[c], tag, da, mA[c]);
      check(db == mB[c], tag, db, mB[c]);
    end
  endtask

  task automatic check_pend(input string tag);
    logic [31:0] da, db, ea, eb;
    logic [7:0] ia;
    ia = '0;
    for (int c = 0; c < 8; c++) begin
      ea = src & mA[c];
      eb = src & mB[c];
      ia[c] = |ea;
      rd(a_st(c), da, db);
      check(da == ea, tag, da, ea);
      check(db == eb, tag, db, eb);
    end
    check(irq_a == ia, "R4 irq vector 8ch", {24'b0, irq_a}, {24'b0, ia});
    check(irq_b == ia[NB-1:0], "R4 irq vector small", 32'(irq_b), 32'(ia[NB-1:0]));
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] da, db, v;
    for (int c = 0; c < 8; c++) begin mA[c] = '0; mB[c] = '0; end
    repeat (3) @(negedge clk);
    arst_n = 1;
    @(negedge clk);

    // R1 reset state
    check(irq_a == 0 && irq_b == 0, "R1 outputs low", 32'(irq_a), 0);
    check(!rv_a && !rv_b, "R9 idle no rvalid", 32'(rv_a), 0);
    check_all_en("R1 enable zero");
    check_pend("R1 pending zero");

    // R2 / R10 distinct masks, with other channels checked after each
    for (int c = 0; c < 8; c++) begin
      wr(a_en(c), pat(c));
      check_all_en("R2 R10 enable store");
    end

    // R3 / R4 walking source
    for (int k = 0; k < 32; k++) begin
      @(negedge clk); src = 32'd1 << k;
      repeat (2) @(negedge clk);
      check_pend("R3 walking pending");
    end
    @(negedge clk); src = 32'hFFFF_FFFF; repeat (2) @(negedge clk);
    check_pend("R3 all sources");
    @(negedge clk); src = 32'h1234_8421; repeat (2) @(negedge clk);
    check_pend("R3 mixed sources");

    // R5 latency and R4 level hold
    wr(a_en(0), 32'h0000_0008);
    @(negedge clk); src = '0; repeat (2) @(negedge clk);
    check(irq_a[0] == 0, "R5 settled low", 32'(irq_a[0]), 0);
    src = 32'h0000_0008;
    @(negedge clk);
    check(irq_a[0] == 0, "R5 not after one edge", 32'(irq_a[0]), 0);
    @(negedge clk);
    check(irq_a[0] == 1, "R5 visible after two edges", 32'(irq_a[0]), 1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(irq_a[0] == 1, "R4 level held", 32'(irq_a[0]), 1);
    end
    src = '0;
    @(negedge clk);
    check(irq_a[0] == 1, "R5 drop delayed", 32'(irq_a[0]), 1);
    @(negedge clk);
    check(irq_a[0] == 0, "R5 drop after two edges", 32'(irq_a[0]), 0);

    // R6 pending writes ignored
    @(negedge clk); src = 32'h00F0_00F0; repeat (2) @(negedge clk);
    for (int c = 0; c < 8; c++) wr(a_st(c), 32'hFFFF_FFFF);
    check_all_en("R6 enable untouched");
    check_pend("R6 pending untouched");
    for (int c = 0; c < 8; c++) wr(a_st(c), 32'h0);
    check_pend("R6 pending not cleared");

    // R7 unmapped offsets
    begin
      logic [11:0] bad [8] = '{12'h000, 12'h014, 12'h030, 12'h011, 12'h204, 12'h210, 12'h810, 12'h03C};
      for (int i = 0; i < 8; i++) begin
        rd(bad[i], da, db);
        check(da == 0 && db == 0, "R7 unmapped read zero", da | db, 0);
        wr(bad[i], 32'hFFFF_FFFF);
      end
      check_all_en("R7 writes ignored");
    end

    // R8 unimplemented slots on the small instance
    for (int c = NB; c < 8; c++) begin
      wr(a_en(c), 32'h5A5A_0000 | 32'(c));
      rd(a_en(c), da, db);
      check(da == (32'h5A5A_0000 | 32'(c)), "R8 big instance stores", da, 32'h5A5A_0000 | 32'(c));
      check(db == 0, "R8 empty slot enable zero", db, 0);
      rd(a_st(c), da, db);
      check(db == 0, "R8 empty slot pending zero", db, 0);
    end
    check_all_en("R8 implemented slots intact");

    // R10 read-modify-write of one bit
    rd(a_en(1), da, db);
    v = da ^ 32'h0000_0400;
    wr(a_en(1), v);
    check_all_en("R10 single bit rmw");
    rd(a_en(1), da, db);
    check((da ^ pat(1)) == 32'h0000_0400, "R10 only one bit changed", da ^ pat(1), 32'h400);
    @(negedge clk); src = 32'hFFFF_FFFF; repeat (2) @(negedge clk);
    check_pend("R3 after rmw");

    // R2 zero write disables all
    for (int c = 0; c < 8; c++) wr(a_en(c), 32'h0);
    check(irq_a == 0 && irq_b == 0, "R2 zero masks silence outputs", 32'(irq_a), 0);
    check_pend("R2 zero masks pending");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule